// File: doc/BRIEF.md
# Vector Lane Move Unit

This unit moves data between a 32-bit scalar value and the lanes of a 128-bit vector. It handles four operations. Two copy one lane out to the scalar side, with sign extension or with zero extension. Insert writes the scalar into one lane and keeps every other lane. Fill broadcasts the scalar into every lane. Elements are bytes, halfwords or words, and the lane index is checked against the element format. The unit sits between a scalar register file and a vector register file, and the caller supplies operands that have already been read.

A request is presented with `in_valid`. One clock later the unit returns the registered result, with one write enable for the scalar side and one for the vector side. It raises `illegal` instead when the format is not supported or the index is past the last lane. Each data output carries meaning only in the cycle where its write enable is high.

Top module: `vlane_move`

## Requirements
- R1: The highest legal lane index is 15 for byte format, 7 for halfword format and 3 for word format. A larger index gives `illegal`=1 with both write enables low.
- R2: Operation code 0 (signed copy) with format code 0 (byte) or 1 (halfword) returns the selected lane sign-extended to 32 bits on `scalar_out`.
- R3: Operation code 1 (unsigned copy) with byte or halfword format returns the selected lane zero-extended to 32 bits, which leaves the upper 24 or 16 bits zero.
- R4: Either copy with format code 2 (word) returns the selected 32-bit lane unchanged.
- R5: Operation code 2 (insert) returns the input vector with lane n replaced by the low 8, 16 or 32 bits of the scalar. All other lanes keep their input values. Lane 0 is the least-significant element, and lane k occupies bits [k*W +: W] for element width W.
- R6: Operation code 3 (fill) returns a vector in which every lane holds the low 8, 16 or 32 bits of the scalar. The input vector is ignored.
- R7: Format code 3 (doubleword) is not supported. It gives `illegal`=1 with both write enables low, for every operation and index.
- R8: For a legal request, `scalar_we` is high only for the copy operations and `vec_we` is high only for insert and fill. The two are never high together.
- R9: The results and flags appear in the first cycle after the clock edge that samples `in_valid`=1. A cycle with no request gives `scalar_we`, `vec_we` and `illegal` all low.
- R10: While reset is held, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| op | input | 2 | 0 signed copy, 1 unsigned copy, 2 insert, 3 fill |
| fmt | input | 2 | 0 byte, 1 halfword, 2 word, 3 unsupported |
| lane_idx | input | 4 | Lane number n |
| scalar_in | input | 32 | Scalar operand |
| vec_in | input | 128 | Vector operand |
| scalar_out | output | 32 | Copied lane value |
| vec_out | output | 128 | Updated vector |
| scalar_we | output | 1 | scalar_out is to be written |
| vec_we | output | 1 | vec_out is to be written |
| illegal | output | 1 | Request rejected for format or index |

## Verification
Every result and flag is due one clock after the edge that samples the request. The bench drives each request just after a falling edge, so the next rising edge captures it, and reads the outputs at the following falling edge, half a period after they settle. It then drops `in_valid` and, every few requests, reads one more idle cycle to confirm that all three flags have returned low. The sweep covers every operation, every format code and all 16 index values against three data patterns. Expected values come from shift-and-mask arithmetic in the bench.

// File: rtl/vlane_pkg.sv
package vlane_pkg;
   typedef enum logic [1:0] {
      OP_COPY_S = 2'd0,
      OP_COPY_U = 2'd1,
      OP_INSERT = 2'd2,
      OP_FILL   = 2'd3
   } vl_op_e;

   typedef enum logic [1:0] {
      FMT_B = 2'd0,
      FMT_H = 2'd1,
      FMT_W = 2'd2,
      FMT_D = 2'd3
   } vl_fmt_e;
endpackage

// File: rtl/vlane_idx_chk.sv
module vlane_idx_chk
   import vlane_pkg::*;
#(
   parameter int VEC_W = 128,
   parameter int IDX_W = $clog2(VEC_W / 8)
) (
   input  vl_fmt_e            fmt,
   input  logic [IDX_W-1:0]   idx,
   output logic               legal
);
   localparam int N_B = VEC_W / 8;
   localparam int N_H = VEC_W / 16;
   localparam int N_W = VEC_W / 32;

   // Width of the index compare, wide enough to hold the largest lane count.
   localparam int CMP_W = IDX_W + 1;

   logic [CMP_W-1:0] idx_x;
   assign idx_x = {1'b0, idx};

   always_comb begin
      unique case (fmt)
         FMT_B:   legal = idx_x < CMP_W'(N_B);
         FMT_H:   legal = idx_x < CMP_W'(N_H);
         FMT_W:   legal = idx_x < CMP_W'(N_W);
         default: legal = 1'b0;
      endcase
   end
endmodule

// File: rtl/vlane_extract.sv
module vlane_extract
   import vlane_pkg::*;
#(
   parameter int VEC_W = 128,
   parameter int SCL_W = 32,
   parameter int IDX_W = $clog2(VEC_W / 8)
) (
   input  logic [VEC_W-1:0]  vec,
   input  vl_fmt_e           fmt,
   input  logic [IDX_W-1:0]  idx,
   input  logic              sign_en,
   output logic [SCL_W-1:0]  value
);
   localparam int OFS_W = IDX_W + 3;

   logic [7:0]       lane_b;
   logic [15:0]      lane_h;
   logic [31:0]      lane_w;
   logic [OFS_W-1:0] ofs_b;
   logic [OFS_W-1:0] ofs_h;
   logic [OFS_W-1:0] ofs_w;

   assign ofs_b  = {idx, 3'b000};
   assign ofs_h  = {idx[IDX_W-2:0], 4'b0000};
   assign ofs_w  = {idx[IDX_W-3:0], 5'b00000};
   assign lane_b = vec[ofs_b +: 8];
   assign lane_h = vec[ofs_h +: 16];
   assign lane_w = vec[ofs_w +: 32];

   always_comb begin
      unique case (fmt)
         FMT_B:   value = {{(SCL_W-8){sign_en & lane_b[7]}}, lane_b};
         FMT_H:   value = {{(SCL_W-16){sign_en & lane_h[15]}}, lane_h};
         FMT_W:   value = lane_w;
         default: value = '0;
      endcase
   end
endmodule

// File: rtl/vlane_merge.sv
module vlane_merge
   import vlane_pkg::*;
#(
   parameter int VEC_W = 128,
   parameter int SCL_W = 32,
   parameter int IDX_W = $clog2(VEC_W / 8)
) (
   input  logic [VEC_W-1:0]  vec,
   input  logic [SCL_W-1:0]  scalar,
   input  vl_fmt_e           fmt,
   input  logic [IDX_W-1:0]  idx,
   input  logic              bcast,
   output logic [VEC_W-1:0]  merged
);
   localparam int N_BYTES = VEC_W / 8;

   // One byte slot per iteration; each slot works out which lane it belongs to
   // and which scalar byte it would take.
   for (genvar g = 0; g < N_BYTES; g++) begin : g_slot
      localparam int LANE_H = g / 2;
      localparam int LANE_W = g / 4;
      localparam int SRC_H  = g % 2;
      localparam int SRC_W  = g % 4;

      logic       hit;
      logic [7:0] src;

      always_comb begin
         unique case (fmt)
            FMT_B: begin
               hit = bcast | (idx == IDX_W'(g));
               src = scalar[7:0];
            end
            FMT_H: begin
               hit = bcast | (idx == IDX_W'(LANE_H));
               src = scalar[SRC_H*8 +: 8];
            end
            FMT_W: begin
               hit = bcast | (idx == IDX_W'(LANE_W));
               src = scalar[SRC_W*8 +: 8];
            end
            default: begin
               hit = 1'b0;
               src = 8'h00;
            end
         endcase
      end

      assign merged[g*8 +: 8] = hit ? src : vec[g*8 +: 8];
   end
endmodule

// File: rtl/vlane_move.sv
module vlane_move
   import vlane_pkg::*;
#(
   parameter int VEC_W = 128,
   parameter int SCL_W = 32,
   parameter int IDX_W = $clog2(VEC_W / 8)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        op,
   input  logic [1:0]        fmt,
   input  logic [IDX_W-1:0]  lane_idx,
   input  logic [SCL_W-1:0]  scalar_in,
   input  logic [VEC_W-1:0]  vec_in,
   output logic [SCL_W-1:0]  scalar_out,
   output logic [VEC_W-1:0]  vec_out,
   output logic              scalar_we,
   output logic              vec_we,
   output logic              illegal
);
   localparam int N_BYTES = VEC_W / 8;

   if (SCL_W != 32) begin : g_bad_scl
      $error("vlane_move: SCL_W must be 32");
   end
   if (VEC_W < 64 || (VEC_W % 32) != 0) begin : g_bad_vec
      $error("vlane_move: VEC_W must be a multiple of 32, at least 64");
   end
   if ((1 << IDX_W) != N_BYTES) begin : g_bad_idx
      $error("vlane_move: IDX_W must equal log2(VEC_W/8)");
   end

   vl_op_e  op_e;
   vl_fmt_e fmt_e;
   assign op_e  = vl_op_e'(op);
   assign fmt_e = vl_fmt_e'(fmt);

   logic             legal;
   logic             is_copy;
   logic [SCL_W-1:0] ext_val;
   logic [VEC_W-1:0] mrg_val;

   assign is_copy = (op_e == OP_COPY_S) | (op_e == OP_COPY_U);

   vlane_idx_chk #(.VEC_W(VEC_W), .IDX_W(IDX_W)) u_chk (
      .fmt   (fmt_e),
      .idx   (lane_idx),
      .legal (legal)
   );

   vlane_extract #(.VEC_W(VEC_W), .SCL_W(SCL_W), .IDX_W(IDX_W)) u_ext (
      .vec     (vec_in),
      .fmt     (fmt_e),
      .idx     (lane_idx),
      .sign_en (op_e == OP_COPY_S),
      .value   (ext_val)
   );

   vlane_merge #(.VEC_W(VEC_W), .SCL_W(SCL_W), .IDX_W(IDX_W)) u_mrg (
      .vec    (vec_in),
      .scalar (scalar_in),
      .fmt    (fmt_e),
      .idx    (lane_idx),
      .bcast  (op_e == OP_FILL),
      .merged (mrg_val)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scalar_out <= '0;
         vec_out    <= '0;
         scalar_we  <= 1'b0;
         vec_we     <= 1'b0;
         illegal    <= 1'b0;
      end else begin
         scalar_we <= in_valid & legal & is_copy;
         vec_we    <= in_valid & legal & ~is_copy;
         illegal   <= in_valid & ~legal;
         if (in_valid) begin
            scalar_out <= ext_val;
            vec_out    <= mrg_val;
         end
      end
   end

   // R8: the two write enables never rise together
   assert_we_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(scalar_we && vec_we));

   // R1: a rejected request writes nothing
   assert_illegal_no_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (!scalar_we && !vec_we));

   // R9: an idle cycle leaves every flag low in the next cycle
   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!scalar_we && !vec_we && !illegal));

   // R7: the unsupported format is rejected one cycle later
   assert_fmt_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && fmt == 2'd3) |=> illegal);

   // R3: an unsigned byte copy leaves the upper bits zero
   assert_zero_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 2'd1 && fmt == 2'd0) |=> (scalar_out[SCL_W-1:8] == '0));

   // R6: a byte fill makes every byte of the vector equal
   assert_fill_uniform_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 2'd3 && fmt == 2'd0) |=>
         (vec_out == {N_BYTES{vec_out[7:0]}}));
endmodule

// File: tb/vlane_move_tb.sv
`timescale 1ns/1ps
module vlane_move_tb_top;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [1:0]   op = '0;
   logic [1:0]   fmt = '0;
   logic [3:0]   lane_idx = '0;
   logic [31:0]  scalar_in = '0;
   logic [127:0] vec_in = '0;
   logic [31:0]  scalar_out;
   logic [127:0] vec_out;
   logic         scalar_we;
   logic         vec_we;
   logic         illegal;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   vlane_move dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .fmt(fmt),
      .lane_idx(lane_idx), .scalar_in(scalar_in), .vec_in(vec_in),
      .scalar_out(scalar_out), .vec_out(vec_out), .scalar_we(scalar_we),
      .vec_we(vec_we), .illegal(illegal)
   );

   task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                      input logic [127:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int esz(input int f);
      return 8 << f;
   endfunction

   function automatic logic [31:0] emask(input int f);
      return (f == 2) ? 32'hFFFF_FFFF : ((32'd1 << esz(f)) - 32'd1);
   endfunction

   function automatic logic [31:0] exp_copy(input logic [127:0] v, input int f,
                                            input int n, input bit sgn);
      logic [31:0] e;
      e = 32'(v >> (n * esz(f))) & emask(f);
      if (sgn && f < 2 && e[esz(f)-1]) e = e | ~emask(f);
      return e;
   endfunction

   function automatic logic [127:0] exp_vec(input logic [127:0] v, input logic [31:0] s,
                                            input int f, input int n, input bit fill);
      logic [127:0] r;
      logic [127:0] lm;
      logic [127:0] sv;
      lm = 128'(emask(f));
      sv = 128'(s & emask(f));
      if (fill) begin
         r = '0;
         for (int l = 0; l < 128 / esz(f); l++) r = r | (sv << (l * esz(f)));
      end else begin
         r = (v & ~(lm << (n * esz(f)))) | (sv << (n * esz(f)));
      end
      return r;
   endfunction

   task automatic run_one(input int o, input int f, input int n,
                          input logic [127:0] v, input logic [31:0] s, input bit idle_chk);
      bit lg;
      @(negedge clk);
      op = 2'(o); fmt = 2'(f); lane_idx = 4'(n); vec_in = v; scalar_in = s;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      lg = (f < 3) && (n < 128 / esz(f));
      if (!lg) begin
         if (f == 3) begin
            chk(illegal && !scalar_we && !vec_we, "R7 reject",
                {illegal, scalar_we, vec_we}, 3'b100);
         end else begin
            chk(illegal && !scalar_we && !vec_we, "R1 reject",
                {illegal, scalar_we, vec_we}, 3'b100);
         end
      end else begin
         chk(!illegal, "R1 accept", illegal, 0);
         if (o < 2) begin
            chk(scalar_we && !vec_we, "R8 copy enables", {scalar_we, vec_we}, 2'b10);
            if (f == 2)
               chk(scalar_out == exp_copy(v, f, n, o == 0), "R4 word copy",
                   scalar_out, exp_copy(v, f, n, o == 0));
            else if (o == 0)
               chk(scalar_out == exp_copy(v, f, n, 1), "R2 signed copy",
                   scalar_out, exp_copy(v, f, n, 1));
            else
               chk(scalar_out == exp_copy(v, f, n, 0), "R3 unsigned copy",
                   scalar_out, exp_copy(v, f, n, 0));
         end else begin
            chk(vec_we && !scalar_we, "R8 vector enables", {scalar_we, vec_we}, 2'b01);
            if (o == 2)
               chk(vec_out == exp_vec(v, s, f, n, 0), "R5 insert",
                   vec_out, exp_vec(v, s, f, n, 0));
            else
               chk(vec_out == exp_vec(v, s, f, n, 1), "R6 fill",
                   vec_out, exp_vec(v, s, f, n, 1));
         end
      end
      if (idle_chk) begin
         @(negedge clk);
         chk(!scalar_we && !vec_we && !illegal, "R9 idle",
             {illegal, scalar_we, vec_we}, 0);
      end
   endtask

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [127:0] pv [3];
      logic [31:0]  ps [3];
      pv[0] = 128'h80FF_7F01_8000_7FFF_F00D_8123_00FE_C3A5;
      pv[1] = {$urandom, $urandom, $urandom, $urandom};
      pv[2] = ~pv[1];
      ps[0] = 32'hFEDC_B98A;
      ps[1] = $urandom;
      ps[2] = 32'h0000_0080;

      // R10: outputs during reset
      in_valid = 1'b1; op = 2'd2; fmt = 2'd0; vec_in = pv[0]; scalar_in = ps[0];
      repeat (3) @(negedge clk);
      chk(scalar_out == '0 && vec_out == '0 && !scalar_we && !vec_we && !illegal,
          "R10 reset", {scalar_out, vec_out[31:0], scalar_we, vec_we, illegal}, 0);
      in_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;

      for (int p = 0; p < 3; p++)
         for (int o = 0; o < 4; o++)
            for (int f = 0; f < 4; f++)
               for (int n = 0; n < 16; n++)
                  run_one(o, f, n, pv[p], ps[p], (n % 4) == 3);

      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule